// File: doc/BRIEF.md
# One-Shot Delayed Pulse Timer

This block produces one delayed pulse each time it is started. A host sets a run bit and two 16-bit compare values over a simple write port. One compare value sets the delay before the pulse. The other sets the count at which the pulse ends. While the run bit is set, a rising edge on the asynchronous trigger input starts the 16-bit up-counter from zero.

When the count reaches the delay value, the output goes active and a one-clock interrupt strobe fires. When the count reaches the end value, a second strobe fires, the output drops one clock later, and the counter returns to zero and waits for the next trigger.

Compare values are not double-buffered. A write takes part in the very next comparison. If a value is lowered below the current count during a run, the counter runs on past its maximum, wraps through zero and only then finds the match. Firmware must allow for this.

Top module: `oneshot_timer`

## Requirements
- R1: After reset, `pulse_o`, `irq_dly_o` and `irq_end_o` are low, the run bit is clear and both compare values are zero.
- R2: A write with `wr_en` high stores `wr_data` on the next rising edge: address 0 sets the run bit from `wr_data[0]`, address 1 sets the delay compare, address 2 sets the end compare, and address 3 changes nothing.
- R3: With the run bit set and the timer idle, a rising edge on `trig_i` starts a sequence. If `trig_i` rises between clock edges, `pulse_o` rises at the (D+4)-th rising clock edge after it, where D is the delay compare.
- R4: `irq_dly_o` is high for exactly one clock, in the first cycle that `pulse_o` is high.
- R5: `irq_end_o` is high for exactly one clock, starting at the (E+4)-th edge after the trigger, where E is the end compare. `pulse_o` falls one edge later, so the pulse lasts E−D+1 clocks.
- R6: After the end match, the counter returns to zero and the timer is idle. A later trigger produces a pulse with identical timing.
- R7: A trigger edge that arrives while a sequence is running is ignored. Timing and strobe counts are unchanged.
- R8: A trigger edge that arrives while the run bit is clear produces no pulse and no strobe.
- R9: Clearing the run bit stops the sequence. `pulse_o` is low from the second edge after the write is presented, no end strobe follows, and the next run starts counting from zero.
- R10: A compare write during a run is used from the next comparison on. Raising either value above the current count moves the corresponding event to the new value in the same run.
- R11: A compare value written below the current count during a run is not matched until the 16-bit count wraps from FFFFH to 0000H and reaches it. The event then occurs 65536 clocks later than the unwrapped value would give.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Host register write strobe |
| wr_addr | input | 2 | Register select: 0 run control, 1 delay compare, 2 end compare |
| wr_data | input | 16 | Write data |
| trig_i | input | 1 | Asynchronous start trigger, rising-edge sensitive |
| pulse_o | output | 1 | One-shot output, active high |
| irq_dly_o | output | 1 | One-clock strobe on the delay match |
| irq_end_o | output | 1 | One-clock strobe on the end match |

## Verification
The hardest state to reach from the ports is the wrap-around after a compare value is lowered mid-run. Reaching it needs a sequence that is already past the new value, followed by a full trip of the counter through FFFFH. The stimulus starts a run with large compare values and schedules writes to both registers at chosen offsets from the trigger. The first strobe is then expected more than 65536 clocks later. A second hard case is a trigger or a run-bit clear landing in the middle of a pulse. The same scheduling mechanism places these at exact cycles, and the bench checks timing against expected edge numbers computed from the trigger cycle.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

  localparam int unsigned REG_ADDR_W = 2;

  localparam logic [REG_ADDR_W-1:0] RA_CTRL = 2'd0;
  localparam logic [REG_ADDR_W-1:0] RA_DLY  = 2'd1;
  localparam logic [REG_ADDR_W-1:0] RA_END  = 2'd2;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_t;

endpackage

// File: rtl/os_regfile.sv
module os_regfile
  import oneshot_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [REG_ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]      wr_data,
  output logic                  run_en,
  output logic [CNT_W-1:0]      cmp_dly,
  output logic [CNT_W-1:0]      cmp_end
);

  logic             run_q;
  logic [CNT_W-1:0] dly_q;
  logic [CNT_W-1:0] end_q;
  logic             we_ctrl;
  logic             we_dly;
  logic             we_end;

  always_comb begin
    we_ctrl = wr_en && (wr_addr == RA_CTRL);
    we_dly  = wr_en && (wr_addr == RA_DLY);
    we_end  = wr_en && (wr_addr == RA_END);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
    end else if (we_ctrl) begin
      run_q <= wr_data[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dly_q <= '0;
    end else if (we_dly) begin
      dly_q <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      end_q <= '0;
    end else if (we_end) begin
      end_q <= wr_data;
    end
  end

  assign run_en  = run_q;
  assign cmp_dly = dly_q;
  assign cmp_end = end_q;

endmodule

// File: rtl/os_trig_sync.sv
module os_trig_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  output logic trig_rise
);

  localparam int unsigned SH_W = STAGES + 1;

  logic [SH_W-1:0] sh_q;
  logic [SH_W-1:0] sh_n;

  always_comb begin
    sh_n = {sh_q[SH_W-2:0], trig_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_n;
    end
  end

  assign trig_rise = sh_q[STAGES-1] && !sh_q[STAGES];

endmodule

// File: rtl/os_seq.sv
module os_seq
  import oneshot_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             start,
  input  logic [CNT_W-1:0] cmp_dly,
  input  logic [CNT_W-1:0] cmp_end,
  output logic             busy,
  output logic [CNT_W-1:0] count,
  output logic             hit_dly,
  output logic             hit_end
);

  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  seq_state_t       state_q;
  seq_state_t       state_n;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_n;
  logic             cnt_en;

  always_comb begin
    hit_dly = (state_q == SEQ_RUN) && (cnt_q == cmp_dly);
    hit_end = (state_q == SEQ_RUN) && (cnt_q == cmp_end);
  end

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    cnt_en  = 1'b0;
    if (!run_en) begin
      state_n = SEQ_IDLE;
      cnt_n   = '0;
      cnt_en  = 1'b1;
    end else begin
      case (state_q)
        SEQ_IDLE: begin
          if (start) begin
            state_n = SEQ_RUN;
            cnt_n   = '0;
            cnt_en  = 1'b1;
          end
        end
        SEQ_RUN: begin
          cnt_en = 1'b1;
          if (hit_end) begin
            state_n = SEQ_IDLE;
            cnt_n   = '0;
          end else begin
            cnt_n = cnt_q + CNT_ONE;
          end
        end
        default: begin
          state_n = SEQ_IDLE;
          cnt_n   = '0;
          cnt_en  = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
    end else begin
      state_q <= state_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_n;
    end
  end

  assign busy  = (state_q == SEQ_RUN);
  assign count = cnt_q;

endmodule

// File: rtl/os_out_stage.sv
module os_out_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  input  logic hit_dly,
  input  logic hit_end,
  output logic pulse_o,
  output logic irq_dly_o,
  output logic irq_end_o
);

  logic pulse_q;
  logic pulse_n;
  logic irqd_q;
  logic irqd_n;
  logic irqe_q;
  logic irqe_n;

  always_comb begin
    pulse_n = pulse_q;
    irqd_n  = 1'b0;
    irqe_n  = 1'b0;
    if (!run_en) begin
      pulse_n = 1'b0;
    end else begin
      irqd_n = hit_dly;
      irqe_n = hit_end;
      if (irqe_q) begin
        pulse_n = 1'b0;
      end else if (hit_dly) begin
        pulse_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
      irqd_q  <= 1'b0;
      irqe_q  <= 1'b0;
    end else begin
      pulse_q <= pulse_n;
      irqd_q  <= irqd_n;
      irqe_q  <= irqe_n;
    end
  end

  assign pulse_o   = pulse_q;
  assign irq_dly_o = irqd_q;
  assign irq_end_o = irqe_q;

endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer
  import oneshot_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [REG_ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]      wr_data,
  input  logic                  trig_i,
  output logic                  pulse_o,
  output logic                  irq_dly_o,
  output logic                  irq_end_o
);

  logic [RST_STAGES-1:0] rst_sh_q;
  logic                  rst_int_n;
  logic                  run_en;
  logic [CNT_W-1:0]      cmp_dly;
  logic [CNT_W-1:0]      cmp_end;
  logic                  trig_rise;
  logic                  busy;
  logic [CNT_W-1:0]      count;
  logic                  hit_dly;
  logic                  hit_end;

  // Reset asserts at once, releases after RST_STAGES clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sh_q <= '0;
    end else begin
      rst_sh_q <= {rst_sh_q[RST_STAGES-2:0], 1'b1};
    end
  end

  assign rst_int_n = rst_sh_q[RST_STAGES-1];

  os_regfile #(.CNT_W(CNT_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .run_en  (run_en),
    .cmp_dly (cmp_dly),
    .cmp_end (cmp_end)
  );

  os_trig_sync #(.STAGES(SYNC_STAGES)) u_trig (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .trig_i    (trig_i),
    .trig_rise (trig_rise)
  );

  os_seq #(.CNT_W(CNT_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .run_en  (run_en),
    .start   (trig_rise),
    .cmp_dly (cmp_dly),
    .cmp_end (cmp_end),
    .busy    (busy),
    .count   (count),
    .hit_dly (hit_dly),
    .hit_end (hit_end)
  );

  os_out_stage u_out (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .run_en    (run_en),
    .hit_dly   (hit_dly),
    .hit_end   (hit_end),
    .pulse_o   (pulse_o),
    .irq_dly_o (irq_dly_o),
    .irq_end_o (irq_end_o)
  );

endmodule

// File: rtl/os_checker.sv
module os_checker #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_en,
  input logic             busy,
  input logic [CNT_W-1:0] count,
  input logic             pulse_o,
  input logic             irq_dly_o,
  input logic             irq_end_o
);

  assert_irq_dly_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_dly_o |=> !irq_dly_o);

  assert_rise_with_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_o) |-> irq_dly_o);

  assert_irq_end_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_end_o |=> !irq_end_o);

  assert_fall_after_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_end_o |=> !pulse_o);

  assert_idle_count_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (count == '0));

  assert_no_strobe_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && !busy) |=> (!irq_dly_o && !irq_end_o));

  assert_stop_on_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (!pulse_o && !busy && (count == '0)));

endmodule

bind oneshot_timer os_checker #(.CNT_W(CNT_W)) u_os_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .run_en    (run_en),
  .busy      (busy),
  .count     (count),
  .pulse_o   (pulse_o),
  .irq_dly_o (irq_dly_o),
  .irq_end_o (irq_end_o)
);

// File: tb/tb_oneshot_timer.sv
`timescale 1ns/1ps
module tb_oneshot_timer;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_addr;
  logic [15:0] wr_data;
  logic        trig_i;
  logic        pulse_o;
  logic        irq_dly_o;
  logic        irq_end_o;

  int cyc = 0;
  int n_tests = 0;
  int n_fail = 0;

  // observation results
  int t_trig, t_rise, t_fall, t_irqd, t_irqe, n_irqd, n_irqe;
  // schedule (offsets from trigger cycle, -1 = none)
  int sw_off [2];
  int sw_addr[2];
  int sw_data[2];
  int rt_off;

  oneshot_timer dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .trig_i    (trig_i),
    .pulse_o   (pulse_o),
    .irq_dly_o (irq_dly_o),
    .irq_end_o (irq_end_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int exp_rise(int t, int d); return t + d + 4; endfunction
  function automatic int exp_end (int t, int e); return t + e + 4; endfunction
  function automatic int exp_fall(int t, int e); return t + e + 5; endfunction

  task automatic check_eq(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("[TB] FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic reg_write(int a, int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a[1:0]; wr_data = d[15:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic clear_sched();
    sw_off[0] = -1; sw_off[1] = -1; rt_off = -1;
  endtask

  task automatic shot(int maxc);
    bit prev;
    t_rise = -1; t_fall = -1; t_irqd = -1; t_irqe = -1;
    n_irqd = 0; n_irqe = 0;
    @(negedge clk);
    trig_i = 1'b1;
    t_trig = cyc;
    prev = pulse_o;
    for (int k = 0; k < maxc; k++) begin
      @(negedge clk);
      if (irq_dly_o) begin n_irqd++; if (t_irqd < 0) t_irqd = cyc; end
      if (irq_end_o) begin n_irqe++; if (t_irqe < 0) t_irqe = cyc; end
      if (pulse_o && !prev && t_rise < 0) t_rise = cyc;
      if (!pulse_o && prev && t_fall < 0) t_fall = cyc;
      prev = pulse_o;
      wr_en = 1'b0;
      if (cyc == t_trig + 3) trig_i = 1'b0;
      if (rt_off >= 0 && cyc == t_trig + rt_off) trig_i = 1'b1;
      if (rt_off >= 0 && cyc == t_trig + rt_off + 3) trig_i = 1'b0;
      for (int i = 0; i < 2; i++) begin
        if (sw_off[i] >= 0 && cyc == t_trig + sw_off[i]) begin
          wr_en = 1'b1; wr_addr = sw_addr[i][1:0]; wr_data = sw_data[i][15:0];
        end
      end
    end
    wr_en = 1'b0;
    trig_i = 1'b0;
  endtask

  task automatic check_normal(string req, int d, int e);
    check_eq({req, " rise"},     t_rise, exp_rise(t_trig, d));
    check_eq({req, " irq_dly"},  t_irqd, exp_rise(t_trig, d));
    check_eq({req, " irq_end"},  t_irqe, exp_end(t_trig, e));
    check_eq({req, " fall"},     t_fall, exp_fall(t_trig, e));
    check_eq({req, " width"},    t_fall - t_rise, e - d + 1);
    check_eq({req, " n_dly"},    n_irqd, 1);
    check_eq({req, " n_end"},    n_irqe, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("[TB] FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5A17));
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; trig_i = 1'b0;
    clear_sched();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1: reset state at ports
    check_eq("R1 pulse_o", pulse_o, 0);
    check_eq("R1 irq_dly_o", irq_dly_o, 0);
    check_eq("R1 irq_end_o", irq_end_o, 0);
    // R1: run bit clear after reset -> trigger ignored
    shot(40);
    check_eq("R1 no pulse while run clear", n_irqd + n_irqe, 0);
    // R1: compares reset to zero -> D=0,E=0 timing
    reg_write(0, 1);
    shot(20);
    check_normal("R1 zero compares", 0, 0);

    // R3 R4 R5 directed
    reg_write(1, 3);
    reg_write(2, 10);
    shot(30);
    check_normal("R3 directed", 3, 10);

    // R2: address 3 has no effect
    reg_write(3, 16'h0005);
    shot(30);
    check_normal("R2 addr3 ignored", 3, 10);

    // R7: retrigger while busy ignored
    reg_write(1, 8);
    reg_write(2, 30);
    rt_off = 15;
    shot(50);
    check_normal("R7 busy retrigger", 8, 30);
    clear_sched();
    // R6: next trigger after idle repeats identically
    shot(50);
    check_normal("R6 repeat", 8, 30);

    // R8: trigger with run clear
    reg_write(0, 0);
    shot(80);
    check_eq("R8 no rise", t_rise, -1);
    check_eq("R8 no strobes", n_irqd + n_irqe, 0);
    reg_write(0, 1);

    // R9: clear run mid-pulse
    reg_write(1, 5);
    reg_write(2, 60);
    sw_off[0] = 20; sw_addr[0] = 0; sw_data[0] = 0;
    shot(90);
    check_eq("R9 rise", t_rise, exp_rise(t_trig, 5));
    check_eq("R9 fall on clear", t_fall, t_trig + 22);
    check_eq("R9 no end strobe", n_irqe, 0);
    clear_sched();
    reg_write(0, 1);
    shot(75);
    check_normal("R9 restart from zero", 5, 60);

    // R10: mid-run raises take effect immediately
    reg_write(1, 40);
    reg_write(2, 50);
    sw_off[0] = 10; sw_addr[0] = 1; sw_data[0] = 20;
    sw_off[1] = 35; sw_addr[1] = 2; sw_data[1] = 70;
    shot(90);
    check_normal("R10 live update", 20, 70);
    clear_sched();

    // R3 R4 R5 random patterns
    for (int it = 0; it < 16; it++) begin
      int d, e;
      d = int'($urandom % 50);
      e = d + int'($urandom % 40);
      if (it == 0) e = d;
      reg_write(1, d);
      reg_write(2, e);
      shot(e + 12);
      check_normal("R5 random", d, e);
    end

    // R11: lower both compares below current count -> wrap
    reg_write(1, 300);
    reg_write(2, 400);
    sw_off[0] = 200; sw_addr[0] = 1; sw_data[0] = 100;
    sw_off[1] = 201; sw_addr[1] = 2; sw_data[1] = 150;
    shot(65536 + 170);
    check_eq("R11 wrap irq_dly", t_irqd, t_trig + 65536 + 104);
    check_eq("R11 wrap rise", t_rise, t_trig + 65536 + 104);
    check_eq("R11 wrap irq_end", t_irqe, t_trig + 65536 + 154);
    check_eq("R11 wrap fall", t_fall, t_trig + 65536 + 155);
    check_eq("R11 single strobes", n_irqd + n_irqe, 2);
    clear_sched();

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule